// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block sits between a memory controller's command scheduler and the pins of a four-bank, 16-bit synchronous DRAM. It takes a read or write burst command with a bank and a start column, and on each following cycle it produces one beat: the column address, the bank, a write/read flag, a last-beat flag and the byte enables for that beat. Row activation, precharge, refresh and the array itself are handled elsewhere.

A small mode register sets three things: the burst length (1, 2, 4, 8 or a full 256-column page), the column ordering (sequential wrap within the aligned block, or interleaved by XOR with the beat count), and the read latency (2 or 3 clocks). For every read beat the block raises `rd_valid` exactly that many cycles after the beat appears, so that the controller knows when to capture the returning data. A burst can be stopped by a terminate command on any cycle, or replaced by a new read or write on any cycle. Read beats that were already issued still come out of the latency pipeline.

All inputs are sampled on the rising clock edge, and all outputs are registers updated on that edge. A command sampled at one edge produces its first beat at the outputs right after that same edge.

Top module: `sdr_burst_seq`

## Requirements
- R1: After reset, `beat_valid`, `beat_last` and `rd_valid` are low. The mode is burst length 1, sequential ordering, read latency 2.
- R2: Opcodes on `cmd_op` are 0 = read, 1 = write, 2 = terminate, 3 = load mode. On a load-mode command, `cmd_col[2:0]` selects the burst length (0→1, 1→2, 2→4, 3→8, 7→full page), `cmd_col[3]` selects interleaved ordering when 1, and `cmd_col[4]` selects read latency 3 when 1 (latency 2 when 0). In sequential ordering, beat n has column `(start & ~(L-1)) | ((start + n) & (L-1))` for burst length L.
- R3: In interleaved ordering, beat n has column `(start & ~(L-1)) | ((start ^ n) & (L-1))`.
- R4: A full-page burst counts sequentially through all 256 columns, wrapping from 255 to 0. It never raises `beat_last` and runs until it is terminated or preempted.
- R5: A load-mode command with burst length code 4, 5 or 6, or with full page together with interleaved ordering, is rejected and the previous mode stays in force.
- R6: For each read beat shown in cycle k, `rd_valid` is high in cycle k+2 (latency 2) or k+3 (latency 3), and at no other time.
- R7: A terminate command clears `beat_valid` at the next edge and ends the burst. Read beats already issued still produce their `rd_valid`.
- R8: A read or write command on any cycle, including mid-burst, replaces the current burst. Its first beat, carrying the start column and the new bank, appears at the next edge.
- R9: On every beat, `beat_be[1]` is the inverse of `cmd_udqm` and `beat_be[0]` is the inverse of `cmd_ldqm`, as sampled at the edge that produced the beat.
- R10: A load-mode command is ignored while a burst is active, a beat is being shown, or read data is still pending in the latency pipeline.
- R11: A finite burst of length L shows exactly L beats on consecutive cycles. `beat_last` is high on the final beat only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Opcode: 0 read, 1 write, 2 terminate, 3 load mode |
| cmd_bank | input | 2 | Target bank of a read or write |
| cmd_col | input | 8 | Start column; carries the mode field on load mode |
| cmd_udqm | input | 1 | High-byte mask for the beat produced at this edge (1 = masked) |
| cmd_ldqm | input | 1 | Low-byte mask for the beat produced at this edge (1 = masked) |
| beat_valid | output | 1 | A beat is being issued |
| beat_write | output | 1 | The beat is part of a write burst |
| beat_bank | output | 2 | Bank of the beat |
| beat_col | output | 8 | Column address of the beat |
| beat_last | output | 1 | Final beat of a finite burst |
| beat_be | output | 2 | Byte enables {high, low}, active high |
| rd_valid | output | 1 | Read data expected this cycle |

## Verification
On every cycle the assertions check five things: a new command's first beat carries its start column and bank, a terminate silences the beat stream, the byte enables follow the sampled masks, `rd_valid` is preceded by a read beat at a legal latency, and the mode stays legal and frozen while the block is busy. The column orderings can only be shown by the scoreboard's beat-by-beat comparison over whole bursts: sequential wrap, XOR interleave and the full-page wrap past column 255. The same holds for exact burst lengths, rejected mode loads, and read beats that drain after a terminate or preempt. Those scenarios also show that `rd_valid` falls on exactly the right cycle rather than merely a legal one.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    localparam int SDR_COL_W  = 8;
    localparam int SDR_BANK_W = 2;
    localparam int SDR_LAT_LO = 2;
    localparam int SDR_LAT_HI = 3;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_TERM  = 2'd2,
        OP_MODE  = 2'd3
    } seq_op_e;

    typedef enum logic [2:0] {
        BL_1    = 3'd0,
        BL_2    = 3'd1,
        BL_4    = 3'd2,
        BL_8    = 3'd3,
        BL_FULL = 3'd7
    } bl_code_e;

    typedef struct packed {
        bl_code_e bl;
        logic     ilv;
        logic     lat3;
    } mode_t;

    localparam mode_t MODE_RESET = '{bl: BL_1, ilv: 1'b0, lat3: 1'b0};

    // Low-bit mask that selects the wrapping part of the column
    function automatic logic [SDR_COL_W-1:0] burst_mask(bl_code_e bl);
        case (bl)
            BL_2:    return SDR_COL_W'(1);
            BL_4:    return SDR_COL_W'(3);
            BL_8:    return SDR_COL_W'(7);
            BL_FULL: return '1;
            default: return '0;
        endcase
    endfunction

    function automatic logic mode_legal(logic [2:0] code, logic ilv);
        case (code)
            3'd0, 3'd1, 3'd2, 3'd3: return 1'b1;
            3'd7:                   return !ilv;
            default:                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sdr_col_gen.sv
module sdr_col_gen
    import sdr_seq_pkg::*;
(
    input  logic [SDR_COL_W-1:0] start,
    input  logic [SDR_COL_W-1:0] cnt,
    input  mode_t                mode,
    output logic [SDR_COL_W-1:0] col,
    output logic                 last
);
    logic [SDR_COL_W-1:0] mask;
    logic [SDR_COL_W-1:0] offset;

    always_comb begin
        mask   = burst_mask(mode.bl);
        offset = mode.ilv ? (start ^ cnt) : (start + cnt);
        col    = (start & ~mask) | (offset & mask);
        last   = (mode.bl != BL_FULL) && ((cnt & mask) == mask);
    end
endmodule

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
    import sdr_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 busy,
    input  logic [SDR_COL_W-1:0] field,
    output mode_t                mode
);
    mode_t cand;

    always_comb begin
        cand.bl   = bl_code_e'(field[2:0]);
        cand.ilv  = field[3];
        cand.lat3 = field[4];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_RESET;
        end else if (load && !busy && mode_legal(field[2:0], field[3])) begin
            mode <= cand;
        end
    end
endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe
    import sdr_seq_pkg::*;
#(
    parameter int DEPTH = SDR_LAT_HI
) (
    input  logic clk,
    input  logic rst,
    input  logic issue,
    input  logic lat3,
    output logic rd_valid,
    output logic pending
);
    logic [DEPTH-1:0] stg;
    int               ins_idx;

    assign ins_idx  = lat3 ? (SDR_LAT_HI - 1) : (SDR_LAT_LO - 1);
    assign rd_valid = stg[0];
    assign pending  = |stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                stg[i] <= ((i == DEPTH - 1) ? 1'b0 : stg[(i + 1) % DEPTH])
                          | (issue && (ins_idx == i));
            end
        end
    end
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
    import sdr_seq_pkg::*;
#(
    parameter int COL_W  = SDR_COL_W,
    parameter int BANK_W = SDR_BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_udqm,
    input  logic              cmd_ldqm,
    output logic              beat_valid,
    output logic              beat_write,
    output logic [BANK_W-1:0] beat_bank,
    output logic [COL_W-1:0]  beat_col,
    output logic              beat_last,
    output logic [1:0]        beat_be,
    output logic              rd_valid
);
    seq_op_e             op;
    logic                new_burst, term, load;
    logic                active_q, wr_q, rd_pending, busy;
    logic [COL_W-1:0]    start_q, cnt_q;
    logic [BANK_W-1:0]   bank_q;
    mode_t               mode_q;
    logic [COL_W-1:0]    gen_col;
    logic                gen_last;
    logic                first_last;

    assign op         = seq_op_e'(cmd_op);
    assign new_burst  = cmd_valid && (op == OP_READ || op == OP_WRITE);
    assign term       = cmd_valid && (op == OP_TERM);
    assign load       = cmd_valid && (op == OP_MODE);
    assign busy       = active_q || beat_valid || rd_pending;
    assign first_last = (mode_q.bl == BL_1);

    sdr_mode_reg u_mode (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .busy  (busy),
        .field (cmd_col),
        .mode  (mode_q)
    );

    sdr_col_gen u_col (
        .start (start_q),
        .cnt   (cnt_q),
        .mode  (mode_q),
        .col   (gen_col),
        .last  (gen_last)
    );

    sdr_rd_pipe #(.DEPTH(SDR_LAT_HI)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .issue    (beat_valid && !beat_write),
        .lat3     (mode_q.lat3),
        .rd_valid (rd_valid),
        .pending  (rd_pending)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q   <= 1'b0;
            wr_q       <= 1'b0;
            start_q    <= '0;
            cnt_q      <= '0;
            bank_q     <= '0;
            beat_valid <= 1'b0;
            beat_write <= 1'b0;
            beat_bank  <= '0;
            beat_col   <= '0;
            beat_last  <= 1'b0;
            beat_be    <= '0;
        end else begin
            beat_be <= ~{cmd_udqm, cmd_ldqm};
            if (new_burst) begin
                start_q    <= cmd_col;
                bank_q     <= cmd_bank;
                wr_q       <= (op == OP_WRITE);
                cnt_q      <= COL_W'(1);
                active_q   <= !first_last;
                beat_valid <= 1'b1;
                beat_write <= (op == OP_WRITE);
                beat_bank  <= cmd_bank;
                beat_col   <= cmd_col;
                beat_last  <= first_last;
            end else if (term) begin
                active_q   <= 1'b0;
                beat_valid <= 1'b0;
                beat_last  <= 1'b0;
            end else if (active_q) begin
                cnt_q      <= cnt_q + COL_W'(1);
                active_q   <= !gen_last;
                beat_valid <= 1'b1;
                beat_write <= wr_q;
                beat_bank  <= bank_q;
                beat_col   <= gen_col;
                beat_last  <= gen_last;
            end else begin
                beat_valid <= 1'b0;
                beat_last  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sdr_burst_seq_chk.sv
module sdr_burst_seq_chk
    import sdr_seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic [1:0] cmd_bank,
    input logic [7:0] cmd_col,
    input logic       cmd_udqm,
    input logic       cmd_ldqm,
    input logic       beat_valid,
    input logic       beat_write,
    input logic [1:0] beat_bank,
    input logic [7:0] beat_col,
    input logic       beat_last,
    input logic [1:0] beat_be,
    input logic       rd_valid,
    input mode_t      mode_q,
    input logic       busy
);
    // R11
    last_needs_beat_chk: assert property (@(posedge clk) disable iff (rst)
        beat_last |-> beat_valid);

    // R8
    first_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == 2'd0 || cmd_op == 2'd1))
        |=> (beat_valid && beat_col == $past(cmd_col) && beat_bank == $past(cmd_bank)));

    // R7
    term_silences_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd2) |=> !beat_valid);

    // R9
    byte_enable_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> (beat_be == ~$past({cmd_udqm, cmd_ldqm})));

    // R6
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(beat_valid && !beat_write, 2) || $past(beat_valid && !beat_write, 3)));

    // R10
    mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mode_q));

    // R5
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        !(mode_q.bl == BL_FULL && mode_q.ilv) && (mode_q.bl inside {BL_1, BL_2, BL_4, BL_8, BL_FULL}));
endmodule

bind sdr_burst_seq sdr_burst_seq_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_bank   (cmd_bank),
    .cmd_col    (cmd_col),
    .cmd_udqm   (cmd_udqm),
    .cmd_ldqm   (cmd_ldqm),
    .beat_valid (beat_valid),
    .beat_write (beat_write),
    .beat_bank  (beat_bank),
    .beat_col   (beat_col),
    .beat_last  (beat_last),
    .beat_be    (beat_be),
    .rd_valid   (rd_valid),
    .mode_q     (mode_q),
    .busy       (busy)
);

// File: tb/test_sdr_burst_seq.sv
module test_sdr_burst_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [1:0] cmd_bank = '0;
    logic [7:0] cmd_col = '0;
    logic       cmd_udqm = 1'b0;
    logic       cmd_ldqm = 1'b0;
    logic       beat_valid, beat_write, beat_last, rd_valid;
    logic [1:0] beat_bank, beat_be;
    logic [7:0] beat_col;

    always #5 clk = ~clk;

    sdr_burst_seq i_sdr_burst_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_udqm(cmd_udqm),
        .cmd_ldqm(cmd_ldqm), .beat_valid(beat_valid), .beat_write(beat_write),
        .beat_bank(beat_bank), .beat_col(beat_col), .beat_last(beat_last),
        .beat_be(beat_be), .rd_valid(rd_valid)
    );

    typedef struct {
        int         cyc;
        logic [1:0] bank;
        logic [7:0] col;
        logic       last;
        logic [1:0] be;
        logic       wr;
    } exp_beat_t;

    exp_beat_t exp_q[$];
    int        rd_q[$];
    int        tests = 0;
    int        fails = 0;
    int        cyc = 0;
    bit        done = 1'b0;
    bit        mon_on = 1'b0;

    // bench model of the requirements
    int   m_bl = 1;
    bit   m_il = 1'b0;
    int   m_lat = 2;
    bit   m_act = 1'b0;
    int   m_cnt = 0;
    int   m_start = 0;
    logic [1:0] m_bank = '0;
    bit   m_wr = 1'b0;
    int   last_beat = -10;
    int   last_rd = -10;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int exp_col(int s, int c);
        int base, off;
        base = s - (s % m_bl);
        off  = s % m_bl;
        if (m_il) return base + (off ^ (c % m_bl));
        return base + ((off + c) % m_bl);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic emit(int nxt, int c, bit u, bit l);
        exp_beat_t b;
        b.cyc  = nxt;
        b.bank = m_bank;
        b.col  = 8'(exp_col(m_start, c));
        b.last = (m_bl != 256) && (c == m_bl - 1);
        b.be   = {~u, ~l};
        b.wr   = m_wr;
        exp_q.push_back(b);
        last_beat = nxt;
        if (!m_wr) begin
            rd_q.push_back(nxt + m_lat);
            last_rd = nxt + m_lat;
        end
        if (b.last) m_act = 1'b0;
    endtask

    // driver: one command slot, pushes expected items for the next edge
    task automatic step(bit v, logic [1:0] op, logic [1:0] bk, logic [7:0] col, bit u, bit l);
        int  k, nxt;
        bit  busy;
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_bank = bk; cmd_col = col;
        cmd_udqm = u; cmd_ldqm = l;
        k    = cyc;
        nxt  = k + 1;
        busy = m_act || (last_beat == k) || (last_rd >= k);
        if (v && (op == 2'd0 || op == 2'd1)) begin
            m_start = col; m_bank = bk; m_wr = (op == 2'd1);
            m_act = 1'b1;
            emit(nxt, 0, u, l);
            m_cnt = 1;
        end else if (v && op == 2'd2) begin
            m_act = 1'b0;
        end else begin
            if (v && op == 2'd3 && !busy) begin
                case (col[2:0])
                    3'd0: begin m_bl = 1;   m_il = col[3]; m_lat = col[4] ? 3 : 2; end
                    3'd1: begin m_bl = 2;   m_il = col[3]; m_lat = col[4] ? 3 : 2; end
                    3'd2: begin m_bl = 4;   m_il = col[3]; m_lat = col[4] ? 3 : 2; end
                    3'd3: begin m_bl = 8;   m_il = col[3]; m_lat = col[4] ? 3 : 2; end
                    3'd7: if (!col[3]) begin m_bl = 256; m_il = 1'b0; m_lat = col[4] ? 3 : 2; end
                    default: ;
                endcase
            end
            if (m_act) begin
                emit(nxt, m_cnt, u, l);
                m_cnt = (m_cnt + 1) % 256;
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 2'd0, 8'd0, 1'b0, 1'b0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
                check(1'b0, "R11", "missing beat at cycle", exp_q[0].cyc, cyc);
                void'(exp_q.pop_front());
            end
            if (beat_valid) begin
                if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
                    check(beat_col == exp_q[0].col, "R2/R3/R4 (R8)", "beat_col", beat_col, exp_q[0].col);
                    check(beat_bank == exp_q[0].bank, "R8", "beat_bank", beat_bank, exp_q[0].bank);
                    check(beat_last == exp_q[0].last, "R11", "beat_last", beat_last, exp_q[0].last);
                    check(beat_be == exp_q[0].be, "R9", "beat_be", beat_be, exp_q[0].be);
                    check(beat_write == exp_q[0].wr, "R8", "beat_write", beat_write, exp_q[0].wr);
                    void'(exp_q.pop_front());
                end else begin
                    check(1'b0, "R7/R11", "unexpected beat col", beat_col, -1);
                end
            end
            while (rd_q.size() > 0 && rd_q[0] < cyc) begin
                check(1'b0, "R6", "missing rd_valid due", rd_q[0], cyc);
                void'(rd_q.pop_front());
            end
            if (rd_valid) begin
                if (rd_q.size() > 0 && rd_q[0] == cyc) begin
                    check(1'b1, "R6", "rd_valid", 1, 1);
                    void'(rd_q.pop_front());
                end else begin
                    check(1'b0, "R6", "unexpected rd_valid at cycle", cyc, -1);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(beat_valid == 1'b0, "R1", "beat_valid after reset", beat_valid, 0);
        check(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
        check(beat_last == 1'b0, "R1", "beat_last after reset", beat_last, 0);
        mon_on = 1'b1;

        // R1 default mode: single beat, latency 2
        step(1'b1, 2'd0, 2'd1, 8'h05, 1'b0, 1'b1);
        idle(5);

        // R2: BL4 sequential, wrap within aligned block
        step(1'b1, 2'd3, 2'd0, 8'h02, 1'b0, 1'b0);
        step(1'b1, 2'd0, 2'd2, 8'h06, 1'b0, 1'b0);
        idle(6);

        // R3 + R9: BL8 interleaved, latency 3, varying masks on a write
        step(1'b1, 2'd3, 2'd0, 8'd27, 1'b0, 1'b0);
        step(1'b1, 2'd1, 2'd2, 8'h0D, 1'b0, 1'b0);
        step(1'b0, 2'd0, 2'd0, 8'd0, 1'b1, 1'b0);
        step(1'b0, 2'd0, 2'd0, 8'd0, 1'b0, 1'b1);
        step(1'b0, 2'd0, 2'd0, 8'd0, 1'b1, 1'b1);
        idle(6);
        step(1'b1, 2'd0, 2'd3, 8'hA6, 1'b0, 1'b0);
        idle(12);

        // R5: illegal loads rejected (full page + interleave, code 5)
        step(1'b1, 2'd3, 2'd0, 8'd15, 1'b0, 1'b0);
        idle(2);
        step(1'b1, 2'd3, 2'd0, 8'd5, 1'b0, 1'b0);
        idle(2);
        step(1'b1, 2'd0, 2'd1, 8'h33, 1'b0, 1'b0);
        idle(12);

        // R4 + R7: full page sequential across 255, then terminate
        step(1'b1, 2'd3, 2'd0, 8'd7, 1'b0, 1'b0);
        step(1'b1, 2'd0, 2'd0, 8'hFD, 1'b0, 1'b0);
        idle(5);
        step(1'b1, 2'd2, 2'd0, 8'd0, 1'b0, 1'b0);
        idle(6);

        // R7: terminate right after the first beat of a write
        step(1'b1, 2'd1, 2'd1, 8'h40, 1'b0, 1'b0);
        step(1'b1, 2'd2, 2'd0, 8'd0, 1'b0, 1'b0);
        idle(4);

        // R8: preempt after three beats and on the very next cycle
        step(1'b1, 2'd3, 2'd0, 8'd3, 1'b0, 1'b0);
        step(1'b1, 2'd0, 2'd0, 8'h10, 1'b0, 1'b0);
        idle(2);
        step(1'b1, 2'd1, 2'd3, 8'h23, 1'b0, 1'b0);
        step(1'b1, 2'd0, 2'd2, 8'h5B, 1'b0, 1'b0);
        idle(12);

        // R10: mode load during a burst is ignored; next burst still BL8
        step(1'b1, 2'd0, 2'd1, 8'h80, 1'b0, 1'b0);
        step(1'b1, 2'd3, 2'd0, 8'd1, 1'b0, 1'b0);
        idle(10);
        step(1'b1, 2'd1, 2'd0, 8'h84, 1'b0, 1'b0);
        idle(12);

        mon_on = 1'b0;
        check(exp_q.size() == 0, "R11", "beats left unchecked", exp_q.size(), 0);
        check(rd_q.size() == 0, "R6", "rd_valid left unchecked", rd_q.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule